// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block predicts branches for instruction fetch. It takes a word-aligned fetch address each cycle. One cycle later it reports whether the instruction at that address is predicted taken, whether the branch target cache holds a target for it, what that target is, and whether a taken prediction must pay a one-cycle fetch bubble because no target was cached. Direction comes from a table of two-bit saturating counters. Targets come from a direct-mapped target cache with a partial tag.

Fetch logic can supply the tested condition at lookup time. It does so when the instruction that sets the condition finished at least two cycles before the branch. In that case the predictor uses the actual condition and ignores the counter. Branch resolution sends back one update per cycle: the branch address, the actual direction and the actual target. An update trains the counter. A taken branch allocates into the target cache. A not-taken branch that hits in the target cache removes its entry. A lookup in the same cycle as an update sees the state after the update. Fetch, decode and pipeline flushing belong to the surrounding logic. A taken prediction that turns out wrong costs the pipeline two cycles.

All addresses on the ports are word addresses. Bit 0 of `lk_addr` corresponds to byte-address bit 2.

Top module: `branch_predictor`

## Requirements
- R1: While `rst` is high on a clock edge, the outputs `pred_valid`, `pred_taken`, `pred_hit`, `pred_bubble` and `pred_target` are all zero on the cycle after that edge.
- R2: The prediction outputs are registered. `pred_valid` equals `lk_valid` from the previous cycle. When `pred_valid` is 0, `pred_taken`, `pred_hit`, `pred_bubble` and `pred_target` are all 0.
- R3: The direction table has 2,048 two-bit counters, indexed by word-address bits [10:0]. Every counter starts at 1. An update with `upd_taken`=1 adds one, up to a ceiling of 3. An update with `upd_taken`=0 subtracts one, down to a floor of 0.
- R4: When `cond_ready` is 0, a valid lookup predicts taken exactly when the indexed counter is 2 or 3.
- R5: When `cond_ready` is 1, a valid lookup predicts taken exactly when `cond_value` is 1, whatever the counter holds.
- R6: The target cache has 256 direct-mapped entries, indexed by word-address bits [7:0]. The tag has 8 bits. Tag bit i is the XOR of every word-address bit at position 8+i+8k, for k = 0, 1, 2 and so on. An update with `upd_taken`=1 writes the entry as valid, with the update's tag and `upd_target`. `pred_hit` is 1 when the indexed entry is valid and its tag equals the lookup's tag. After reset every entry is invalid.
- R7: An update with `upd_taken`=0 invalidates its indexed entry only when that entry is valid with a matching tag. Otherwise it leaves the entry unchanged, including an entry that belongs to an aliasing address.
- R8: `pred_target` carries the cached target only when the prediction is taken and hits. Otherwise it is 0. `pred_bubble` is 1 exactly when the prediction is taken and misses.
- R9: When a lookup and an update fall in the same cycle on the same counter index or the same target-cache index, the lookup sees the state after that update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_addr | input | 30 | Fetch word address to predict |
| cond_ready | input | 1 | The tested condition is already resolved |
| cond_value | input | 1 | Resolved condition: 1 means the branch goes |
| upd_valid | input | 1 | A resolved branch update is presented |
| upd_addr | input | 30 | Word address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | 30 | Actual target word address |
| pred_valid | output | 1 | Prediction for the previous cycle's lookup |
| pred_taken | output | 1 | Predicted taken |
| pred_hit | output | 1 | Target cache hit |
| pred_target | output | 30 | Predicted target word address, or 0 |
| pred_bubble | output | 1 | Taken prediction without a cached target |

## Verification
The assertions assume that `lk_valid`, `upd_valid` and the other inputs carry defined values on every edge. They also assume that `upd_valid` stays low while `rst` is high, so the two-cycle target-cache property never looks back at an update issued during reset. Every bench task drives all inputs at the falling edge, and the bench holds updates off while reset is asserted.

Addresses come from a small pool. The pool contains pairs that share a counter index but differ in tag, and pairs that share a target-cache index but differ in counter index. This exercises aliasing, invalidation by a foreign tag, and the same-cycle forwarding between an update and a lookup.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd1;
  localparam ctr_t CTR_MAX  = 2'd3;

  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t n;
    if (taken) n = (c == CTR_MAX) ? c : c + 2'd1;
    else       n = (c == 2'd0)    ? c : c - 2'd1;
    return n;
  endfunction

endpackage

// File: rtl/bpred_bht.sv
module bpred_bht
  import bpred_pkg::*;
#(
  parameter int ENTRIES = 2048,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic          upd_taken,
  input  logic [IW-1:0] lk_idx,
  output ctr_t          lk_ctr
);

  ctr_t table_q [ENTRIES] = '{default: CTR_INIT};
  ctr_t upd_new;

  assign upd_new = ctr_step(table_q[upd_idx], upd_taken);

  always_ff @(posedge clk) begin
    if (upd_en) table_q[upd_idx] <= upd_new;
  end

  // same-cycle write is forwarded to the lookup
  assign lk_ctr = (upd_en && upd_idx == lk_idx) ? upd_new : table_q[lk_idx];

endmodule

// File: rtl/bpred_btac.sv
module bpred_btac #(
  parameter int ENTRIES = 256,
  parameter int TAG_W   = 8,
  parameter int TGT_W   = 30,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [IW-1:0]    upd_idx,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             upd_taken,
  input  logic [TGT_W-1:0] upd_target,
  input  logic [IW-1:0]    lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [TGT_W-1:0] lk_target
);

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  logic [TGT_W-1:0]   tgt_mem [ENTRIES];

  logic             upd_match;
  logic             same_idx;
  logic             e_vld;
  logic [TAG_W-1:0] e_tag;

  assign upd_match = vld_q[upd_idx] && (tag_mem[upd_idx] == upd_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (upd_en) begin
      if (upd_taken)      vld_q[upd_idx] <= 1'b1;
      else if (upd_match) vld_q[upd_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en && upd_taken) begin
      tag_mem[upd_idx] <= upd_tag;
      tgt_mem[upd_idx] <= upd_target;
    end
  end

  assign same_idx  = upd_en && (upd_idx == lk_idx);
  assign e_vld     = same_idx ? (upd_taken || (vld_q[lk_idx] && !upd_match)) : vld_q[lk_idx];
  assign e_tag     = (same_idx && upd_taken) ? upd_tag    : tag_mem[lk_idx];
  assign lk_target = (same_idx && upd_taken) ? upd_target : tgt_mem[lk_idx];
  assign lk_hit    = e_vld && (e_tag == lk_tag);

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor
  import bpred_pkg::*;
#(
  parameter int ADDR_W       = 30,
  parameter int BHT_ENTRIES  = 2048,
  parameter int BTAC_ENTRIES = 256,
  parameter int TAG_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              cond_ready,
  input  logic              cond_value,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic              pred_hit,
  output logic [ADDR_W-1:0] pred_target,
  output logic              pred_bubble
);

  localparam int BHT_IW  = $clog2(BHT_ENTRIES);
  localparam int BTAC_IW = $clog2(BTAC_ENTRIES);

  function automatic logic [TAG_W-1:0] fold_tag(input logic [ADDR_W-1:0] a);
    logic [TAG_W-1:0] t;
    t = '0;
    for (int i = BTAC_IW; i < ADDR_W; i++) t[(i - BTAC_IW) % TAG_W] ^= a[i];
    return t;
  endfunction

  ctr_t              lk_ctr;
  logic              lk_hit;
  logic [ADDR_W-1:0] lk_tgt;
  logic              taken_c;
  logic              hit_c;

  bpred_bht #(.ENTRIES(BHT_ENTRIES)) u_bht (
    .clk       (clk),
    .upd_en    (upd_valid),
    .upd_idx   (upd_addr[BHT_IW-1:0]),
    .upd_taken (upd_taken),
    .lk_idx    (lk_addr[BHT_IW-1:0]),
    .lk_ctr    (lk_ctr)
  );

  bpred_btac #(.ENTRIES(BTAC_ENTRIES), .TAG_W(TAG_W), .TGT_W(ADDR_W)) u_btac (
    .clk        (clk),
    .rst        (rst),
    .upd_en     (upd_valid),
    .upd_idx    (upd_addr[BTAC_IW-1:0]),
    .upd_tag    (fold_tag(upd_addr)),
    .upd_taken  (upd_taken),
    .upd_target (upd_target),
    .lk_idx     (lk_addr[BTAC_IW-1:0]),
    .lk_tag     (fold_tag(lk_addr)),
    .lk_hit     (lk_hit),
    .lk_target  (lk_tgt)
  );

  // a resolved condition wins over the counter
  assign taken_c = lk_valid && (cond_ready ? cond_value : lk_ctr[1]);
  assign hit_c   = lk_valid && lk_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid  <= 1'b0;
      pred_taken  <= 1'b0;
      pred_hit    <= 1'b0;
      pred_target <= '0;
      pred_bubble <= 1'b0;
    end else begin
      pred_valid  <= lk_valid;
      pred_taken  <= taken_c;
      pred_hit    <= hit_c;
      pred_target <= (taken_c && hit_c) ? lk_tgt : '0;
      pred_bubble <= taken_c && !hit_c;
    end
  end

endmodule

// File: rtl/branch_predictor_checker.sv
module branch_predictor_checker #(
  parameter int ADDR_W = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              cond_ready,
  input logic              cond_value,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_addr,
  input logic              upd_taken,
  input logic [ADDR_W-1:0] upd_target,
  input logic              pred_valid,
  input logic              pred_taken,
  input logic              pred_hit,
  input logic [ADDR_W-1:0] pred_target,
  input logic              pred_bubble
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !pred_valid && !pred_taken && !pred_hit && !pred_bubble && pred_target == '0);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid);

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |-> !pred_taken && !pred_hit && !pred_bubble && pred_target == '0);

  assert_override_R5: assert property (@(posedge clk) disable iff (rst)
    lk_valid && cond_ready |=> pred_taken == $past(cond_value));

  assert_alloc_hit_R6: assert property (@(posedge clk) disable iff (rst)
    upd_valid && upd_taken ##1 (lk_valid && !upd_valid && lk_addr == $past(upd_addr))
    |=> pred_hit && (!pred_taken || pred_target == $past(upd_target, 2)));

  assert_invalidate_R7: assert property (@(posedge clk) disable iff (rst)
    upd_valid && !upd_taken ##1 (lk_valid && !upd_valid && lk_addr == $past(upd_addr))
    |=> !pred_hit);

  assert_bubble_R8: assert property (@(posedge clk) disable iff (rst)
    pred_bubble |-> pred_taken && !pred_hit);

  assert_no_bubble_on_hit_R8: assert property (@(posedge clk) disable iff (rst)
    pred_taken && pred_hit |-> !pred_bubble);

  assert_target_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !(pred_taken && pred_hit) |-> pred_target == '0);

endmodule

bind branch_predictor branch_predictor_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .cond_ready(cond_ready), .cond_value(cond_value), .upd_valid(upd_valid),
  .upd_addr(upd_addr), .upd_taken(upd_taken), .upd_target(upd_target),
  .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_hit(pred_hit),
  .pred_target(pred_target), .pred_bubble(pred_bubble)
);

// File: tb/branch_predictor_test.sv
module branch_predictor_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 30;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lk_valid = 1'b0, cond_ready = 1'b0, cond_value = 1'b0;
  logic [AW-1:0] lk_addr = '0, upd_addr = '0, upd_target = '0;
  logic          upd_valid = 1'b0, upd_taken = 1'b0;
  logic          pred_valid, pred_taken, pred_hit, pred_bubble;
  logic [AW-1:0] pred_target;

  int tests = 0;
  int fails = 0;
  string phase = "init";

  // behavioural reference state
  int            m_ctr [2048];
  bit            m_vld [256];
  logic [7:0]    m_tag [256];
  logic [AW-1:0] m_tgt [256];
  logic          e_valid, e_taken, e_hit, e_bubble, e_cr;
  logic [AW-1:0] e_target;

  branch_predictor uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .cond_ready(cond_ready), .cond_value(cond_value), .upd_valid(upd_valid),
    .upd_addr(upd_addr), .upd_taken(upd_taken), .upd_target(upd_target),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_hit(pred_hit),
    .pred_target(pred_target), .pred_bubble(pred_bubble)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [7:0] tag_of(logic [AW-1:0] a);
    logic [7:0] t = '0;
    for (int i = 8; i < AW; i++) t[(i - 8) % 8] ^= a[i];
    return t;
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s]: actual=%h expected=%h", req, phase, act, exp);
    end
  endtask

  // drive one cycle, advance the model, compare the registered result
  task automatic step(bit lv, logic [AW-1:0] la, bit cr, bit cv,
                      bit uv, logic [AW-1:0] ua, bit ut, logic [AW-1:0] ug);
    int li, ui, bi, lb;
    lk_valid = lv; lk_addr = la; cond_ready = cr; cond_value = cv;
    upd_valid = uv; upd_addr = ua; upd_taken = ut; upd_target = ug;
    if (uv) begin
      ui = int'(ua[10:0]);
      bi = int'(ua[7:0]);
      m_ctr[ui] = ut ? ((m_ctr[ui] == 3) ? 3 : m_ctr[ui] + 1)
                     : ((m_ctr[ui] == 0) ? 0 : m_ctr[ui] - 1);
      if (ut) begin
        m_vld[bi] = 1'b1; m_tag[bi] = tag_of(ua); m_tgt[bi] = ug;
      end else if (m_vld[bi] && m_tag[bi] == tag_of(ua)) begin
        m_vld[bi] = 1'b0;
      end
    end
    li = int'(la[10:0]);
    lb = int'(la[7:0]);
    e_valid  = lv;
    e_cr     = cr;
    e_hit    = lv && m_vld[lb] && m_tag[lb] == tag_of(la);
    e_taken  = lv && (cr ? cv : (m_ctr[li] >= 2));
    e_target = (e_taken && e_hit) ? m_tgt[lb] : '0;
    e_bubble = e_taken && !e_hit;
    @(posedge clk);
    @(negedge clk);
    check("R2", AW'(pred_valid), AW'(e_valid));
    check(e_cr ? "R5" : "R4", AW'(pred_taken), AW'(e_taken));
    check("R6", AW'(pred_hit), AW'(e_hit));
    check("R8", pred_target, e_target);
    check("R8", AW'(pred_bubble), AW'(e_bubble));
  endtask

  task automatic look(logic [AW-1:0] a);
    step(1, a, 0, 0, 0, '0, 0, '0);
  endtask

  task automatic train(logic [AW-1:0] a, bit t, logic [AW-1:0] g);
    step(0, '0, 0, 0, 1, a, t, g);
  endtask

  localparam logic [AW-1:0] PA = 30'h400;
  localparam logic [AW-1:0] PB = 30'h500;   // same target-cache index as PA
  localparam logic [AW-1:0] PC = 30'hC00;   // same counter index as PA
  localparam logic [AW-1:0] PD = 30'h123;
  localparam logic [AW-1:0] PE = 30'h7FF;
  localparam logic [AW-1:0] PF = 30'h3FFFFFFF;

  initial begin
    logic [AW-1:0] pool [6];
    pool[0] = PA; pool[1] = PB; pool[2] = PC;
    pool[3] = PD; pool[4] = PE; pool[5] = PF;
    for (int i = 0; i < 2048; i++) m_ctr[i] = 1;
    for (int i = 0; i < 256; i++) m_vld[i] = 1'b0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    phase = "R1 reset";
    check("R1", AW'(pred_valid), '0);
    check("R1", AW'(pred_taken | pred_hit | pred_bubble), '0);
    check("R1", pred_target, '0);
    rst = 1'b0;

    phase = "R4 initial counter";
    look(PA);
    phase = "R3 train up";
    train(PA, 1, 30'h2222);
    look(PA);
    train(PA, 1, 30'h2222);
    train(PA, 1, 30'h2222);
    train(PA, 1, 30'h2222);
    look(PA);
    phase = "R3 saturate down";
    train(PA, 0, 30'h0);
    look(PA);
    for (int i = 0; i < 5; i++) train(PA, 0, 30'h0);
    look(PA);
    phase = "R5 override";
    step(1, PA, 1, 1, 0, '0, 0, '0);
    for (int i = 0; i < 4; i++) train(PD, 1, 30'h1111);
    step(1, PD, 1, 0, 0, '0, 0, '0);
    step(1, PD, 1, 1, 0, '0, 0, '0);
    phase = "R7 alias invalidate";
    train(PB, 1, 30'h3333);
    train(PA, 0, 30'h0);
    step(1, PB, 0, 0, 0, '0, 0, '0);
    step(1, PB, 1, 1, 0, '0, 0, '0);
    train(PB, 0, 30'h0);
    step(1, PB, 1, 1, 0, '0, 0, '0);
    phase = "R6 shared counter";
    train(PC, 1, 30'h4444);
    step(1, PC, 1, 1, 0, '0, 0, '0);
    step(1, PA, 1, 1, 0, '0, 0, '0);
    phase = "R9 same-cycle forward";
    step(1, PE, 0, 0, 1, PE, 1, 30'h5555);
    step(1, PE, 0, 0, 1, PE, 1, 30'h6666);
    step(1, PE, 0, 0, 1, PE, 0, 30'h0);
    step(1, PF, 0, 0, 1, PF - 30'h100, 1, 30'h7777);

    phase = "R9 mixed traffic";
    for (int n = 0; n < 3000; n++) begin
      automatic int r = $urandom;
      step(r[0], pool[$urandom % 6], r[1] & r[2], r[3],
           r[4], pool[$urandom % 6], r[5] | r[6], AW'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule